// File: doc/BRIEF.md
# Serial Input Delay Calibrator

This block chooses the sampling delay for a serial read-data input. On a start strobe it walks through every delay setting from the smallest up. At each step it first drives the setting onto the sampler's delay control. It then sends one read of a known test register through a request/response command port. A setting passes only when the returned word equals a known constant. Each result goes into a pass mask with one bit per setting.

When the sweep ends, a fixed policy turns the mask into one final setting. A single pass selects that setting. For two adjacent passes, the block takes the one that sits on the edge of the delay range, or the lower one if neither does. Three passes select the middle setting, and four select the lower of the two middle settings. An empty mask or one with a gap is a calibration failure. The final setting then stays on the delay output. A one-cycle done pulse reports completion, together with the selected value and an error flag.

Both command channels use valid/ready. On the request channel the calibrator holds valid, the address and its delay setting until the engine accepts the request, so the engine may stall it for as long as it needs. On the response channel the calibrator asserts ready only while a read is outstanding. A response word is consumed in the cycle where valid and ready are both high. The engine may stall for any number of cycles before it answers.

Top module: `rx_sample_delay_cal`

## Requirements
- R1: In reset, and until the first start, the outputs are quiet: delay output 0, done 0, error 0, selected value 0 and no read request.
- R2: A start while idle begins a sweep that issues exactly four reads, all to the test address (default 8'h01). During the n-th read (n = 0..3) the delay output equals n.
- R3: A setting passes only when its read returns exactly the test constant (default 16'h5AA5). Any other word, even one differing in one bit, fails it. Bit n of the pass mask records setting n.
- R4: When exactly one setting passes, that setting is selected.
- R5: With two adjacent passes, mask 4'b0011 selects 0, 4'b1100 selects 3 and 4'b0110 selects 1.
- R6: With three contiguous passes, the middle one is selected: 4'b0111 gives 1 and 4'b1110 gives 2.
- R7: When all four settings pass, setting 1 is selected.
- R8: An all-zero or non-contiguous mask sets the error flag. In that case the selected value and the delay output both return to 0.
- R9: After a successful sweep the delay output equals the selected value and holds it until the next start.
- R10: A start during a sweep is ignored. No extra read is issued, only one done pulse occurs and the result is unchanged.
- R11: Done is high for exactly one cycle per sweep. The error flag stays set until the next accepted start clears it.
- R12: A pending read request keeps valid, the address and the delay output steady until the engine accepts it, however long the engine stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a calibration sweep (accepted only when idle) |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Engine accepts the read request |
| rd_req_addr_o | output | 8 | Address of the test register |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_ready_o | output | 1 | Calibrator waits for a response |
| rd_rsp_data_i | input | 16 | Read response data |
| dly_sel_o | output | 2 | Delay setting driven to the input sampler |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Calibration failure, held until next start |
| sel_o | output | 2 | Selected delay setting of the last sweep |

## Verification
The in-design checks assume the engine follows the protocol. It answers only a read it has accepted, and it presents at most one response per request, so no response arrives while no read is outstanding. The bench model keeps to this. It records a request only in a cycle where valid and ready are both high, and it raises the response a set number of cycles later. It keeps the response up until the handshake, then drops it. Ready on the request side can be stalled in a fixed pattern. This exercises back-pressure without ever breaking the one-outstanding-read order.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE,
    CAL_ISSUE,
    CAL_WAIT,
    CAL_DECIDE
  } cal_state_e;
endpackage

// File: rtl/cal_sweep_ctrl.sv
module cal_sweep_ctrl
  import cal_pkg::*;
#(
  parameter int DLY_W  = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] TEST_ADDR  = 8'h01,
  parameter logic [DATA_W-1:0] TEST_VALUE = 16'h5AA5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  output logic                    req_valid_o,
  input  logic                    req_ready_i,
  output logic [ADDR_W-1:0]       req_addr_o,
  input  logic                    rsp_valid_i,
  output logic                    rsp_ready_o,
  input  logic [DATA_W-1:0]       rsp_data_i,
  output logic [DLY_W-1:0]        sweep_dly_o,
  output logic [(1<<DLY_W)-1:0]   pass_mask_o,
  output logic                    busy_o,
  output logic                    launch_o,
  output logic                    decide_o
);
  localparam int NUM_SET = 1 << DLY_W;

  cal_state_e           state_q;
  logic [DLY_W-1:0]     idx_q;
  logic [NUM_SET-1:0]   mask_q;
  logic                 rsp_fire;

  assign launch_o    = (state_q == CAL_IDLE) && start_i;
  assign busy_o      = (state_q != CAL_IDLE);
  assign decide_o    = (state_q == CAL_DECIDE);
  assign req_valid_o = (state_q == CAL_ISSUE);
  assign req_addr_o  = TEST_ADDR;
  assign rsp_ready_o = (state_q == CAL_WAIT);
  assign rsp_fire    = rsp_ready_o && rsp_valid_i;
  assign sweep_dly_o = idx_q;
  assign pass_mask_o = mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CAL_IDLE;
      idx_q   <= '0;
      mask_q  <= '0;
    end else begin
      unique case (state_q)
        CAL_IDLE: begin
          if (start_i) begin
            idx_q   <= '0;
            mask_q  <= '0;
            state_q <= CAL_ISSUE;
          end
        end
        CAL_ISSUE: begin
          if (req_ready_i) state_q <= CAL_WAIT;
        end
        CAL_WAIT: begin
          if (rsp_fire) begin
            mask_q[idx_q] <= (rsp_data_i == TEST_VALUE);
            if (&idx_q) begin
              state_q <= CAL_DECIDE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= CAL_ISSUE;
            end
          end
        end
        CAL_DECIDE: state_q <= CAL_IDLE;
        default:    state_q <= CAL_IDLE;
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(sweep_dly_o));

  // R2
  dly_wait_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready_o && !rsp_valid_i |=> $stable(sweep_dly_o));

  // R10
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !decide_o && start_i |=> busy_o);

  // R2
  issue_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> req_valid_o && (sweep_dly_o == '0));
endmodule

// File: rtl/cal_mask_picker.sv
module cal_mask_picker #(
  parameter int DLY_W = 2
) (
  input  logic [(1<<DLY_W)-1:0] mask_i,
  output logic [DLY_W-1:0]      sel_o,
  output logic                  ok_o
);
  localparam int NUM_SET = 1 << DLY_W;
  localparam int CNT_W   = DLY_W + 1;
  localparam logic [DLY_W-1:0] TOP_IDX = DLY_W'(NUM_SET - 1);

  logic [DLY_W-1:0] lo, hi;
  logic             found;
  logic [CNT_W-1:0] cnt, span, mid_off;

  always_comb begin
    lo    = '0;
    hi    = '0;
    found = 1'b0;
    cnt   = '0;
    for (int i = 0; i < NUM_SET; i++) begin
      if (mask_i[i]) begin
        if (!found) lo = DLY_W'(i);
        found = 1'b1;
        hi    = DLY_W'(i);
        cnt   = cnt + 1'b1;
      end
    end
    span    = {1'b0, hi} - {1'b0, lo} + 1'b1;
    ok_o    = found && (cnt == span);
    mid_off = (cnt - 1'b1) >> 1;
    if (cnt == CNT_W'(2)) begin
      if (lo == '0)           sel_o = lo;
      else if (hi == TOP_IDX) sel_o = hi;
      else                    sel_o = lo;
    end else begin
      sel_o = lo + mid_off[DLY_W-1:0];
    end
  end

  // R4
  always_comb begin
    if (ok_o) begin
      sel_passed_chk: assert (mask_i[sel_o]);
    end
  end
endmodule

// File: rtl/rx_sample_delay_cal.sv
module rx_sample_delay_cal #(
  parameter int DLY_W  = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] TEST_ADDR  = 8'h01,
  parameter logic [DATA_W-1:0] TEST_VALUE = 16'h5AA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  output logic              rd_rsp_ready_o,
  input  logic [DATA_W-1:0] rd_rsp_data_i,
  output logic [DLY_W-1:0]  dly_sel_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DLY_W-1:0]  sel_o
);
  localparam int NUM_SET = 1 << DLY_W;

  logic [DLY_W-1:0]   sweep_dly, pick_sel, final_dly_q, sel_q;
  logic [NUM_SET-1:0] pass_mask;
  logic               busy, launch, decide, pick_ok;
  logic               done_q, err_q;

  cal_sweep_ctrl #(
    .DLY_W(DLY_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TEST_ADDR(TEST_ADDR), .TEST_VALUE(TEST_VALUE)
  ) u_sweep (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .req_valid_o (rd_req_valid_o),
    .req_ready_i (rd_req_ready_i),
    .req_addr_o  (rd_req_addr_o),
    .rsp_valid_i (rd_rsp_valid_i),
    .rsp_ready_o (rd_rsp_ready_o),
    .rsp_data_i  (rd_rsp_data_i),
    .sweep_dly_o (sweep_dly),
    .pass_mask_o (pass_mask),
    .busy_o      (busy),
    .launch_o    (launch),
    .decide_o    (decide)
  );

  cal_mask_picker #(.DLY_W(DLY_W)) u_pick (
    .mask_i (pass_mask),
    .sel_o  (pick_sel),
    .ok_o   (pick_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      final_dly_q <= '0;
      sel_q       <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= decide;
      if (launch) err_q <= 1'b0;
      if (decide) begin
        err_q       <= !pick_ok;
        sel_q       <= pick_ok ? pick_sel : '0;
        final_dly_q <= pick_ok ? pick_sel : '0;
      end
    end
  end

  assign dly_sel_o = busy ? sweep_dly : final_dly_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign sel_o     = sel_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

  // R9
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !launch |=> $stable(dly_sel_o));

  // R9
  dly_matches_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> dly_sel_o == sel_o);
endmodule

// File: tb/tb_rx_sample_delay_cal.sv
module tb_rx_sample_delay_cal;
  localparam logic [15:0] PASS_WORD = 16'h5AA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_valid, req_ready = 1'b0;
  logic [7:0]  req_addr;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [15:0] rsp_data = '0;
  logic [1:0]  dly_sel, sel;
  logic        done, err;

  int tests = 0, fails = 0;
  int req_cnt = 0, order_err = 0, cyc = 0, wait_cnt = 0, lat = 1;
  bit stall = 0, pend = 0, fire_next = 0;
  logic [1:0] pend_dly = '0;
  logic [3:0] pass_cfg = '0;

  always #4 clk = ~clk;

  rx_sample_delay_cal dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .rd_req_valid_o(req_valid), .rd_req_ready_i(req_ready),
    .rd_req_addr_o(req_addr), .rd_rsp_valid_i(rsp_valid),
    .rd_rsp_ready_o(rsp_ready), .rd_rsp_data_i(rsp_data),
    .dly_sel_o(dly_sel), .done_o(done), .err_o(err), .sel_o(sel)
  );

  // Read engine model: one outstanding read, response after lat cycles.
  always @(negedge clk) begin
    cyc++;
    if (fire_next) begin rsp_valid = 1'b0; fire_next = 0; end
    if (pend) begin
      if (wait_cnt > 0) wait_cnt--;
      else begin
        rsp_valid = 1'b1;
        rsp_data  = pass_cfg[pend_dly] ? PASS_WORD : (PASS_WORD ^ 16'h0001);
        pend = 0;
      end
    end
    fire_next = rsp_valid && rsp_ready;
    req_ready = stall ? ((cyc % 3) == 0) : 1'b1;
    if (rst_n && req_valid && req_ready) begin
      if (dly_sel != req_cnt[1:0] || req_addr != 8'h01) order_err++;
      pend_dly = dly_sel;
      pend     = 1;
      wait_cnt = lat;
      req_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void expect_pick(input logic [3:0] m, output bit e, output int s);
    e = 0; s = 0;
    case (m)
      4'b0001: s = 0;  4'b0010: s = 1;  4'b0100: s = 2;  4'b1000: s = 3;
      4'b0011: s = 0;  4'b0110: s = 1;  4'b1100: s = 3;
      4'b0111: s = 1;  4'b1110: s = 2;  4'b1111: s = 1;
      default: e = 1;
    endcase
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    int n = 0;
    seen = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    seen = done;
  endtask

  task automatic run_cal(input logic [3:0] m, input bit stl, input int lt);
    bit seen, e;
    int s;
    pass_cfg = m; stall = stl; lat = lt;
    req_cnt = 0; order_err = 0;
    expect_pick(m, e, s);
    pulse_start();
    wait_done(seen);
    chk(seen, "R11 done", seen, 1);
    chk(req_cnt == 4, "R2 read count", req_cnt, 4);
    chk(order_err == 0, "R2/R12 order/addr", order_err, 0);
    chk(err == e, e ? "R8 err" : "R3 err", err, e);
    if (e) begin
      chk(sel == 0, "R8 sel", sel, 0);
      chk(dly_sel == 0, "R8 dly", dly_sel, 0);
    end else if ($countones(m) == 1) chk(sel == s, "R4 sel", sel, s);
    else if ($countones(m) == 2) chk(sel == s, "R5 sel", sel, s);
    else if ($countones(m) == 3) chk(sel == s, "R6 sel", sel, s);
    else chk(sel == s, "R7 sel", sel, s);
    @(negedge clk);
    chk(done == 0, "R11 pulse width", done, 0);
    repeat (5) @(negedge clk);
    chk(dly_sel == (e ? 0 : s), "R9 dly held", dly_sel, e ? 0 : s);
    chk(err == e, "R11 err held", err, e);
  endtask

  task automatic test_reset();
    chk(dly_sel == 0, "R1 dly", dly_sel, 0);
    chk(done == 0 && err == 0, "R1 done/err", {done, err}, 0);
    chk(sel == 0, "R1 sel", sel, 0);
    chk(req_valid == 0, "R1 req", req_valid, 0);
  endtask

  task automatic test_restart();
    bit seen;
    int dones = 0;
    pass_cfg = 4'b0110; stall = 1; lat = 3;
    req_cnt = 0; order_err = 0;
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    wait_done(seen);
    chk(seen && sel == 1, "R10 result", sel, 1);
    repeat (30) begin @(negedge clk); if (done) dones++; end
    chk(dones == 0, "R10 extra done", dones, 0);
    chk(req_cnt == 4, "R10 read count", req_cnt, 4);
  endtask

  task automatic test_err_clear();
    run_cal(4'b1001, 0, 1);
    pass_cfg = 4'b0001; req_cnt = 0; order_err = 0;
    pulse_start();
    chk(err == 0, "R11 err cleared by start", err, 1'b0);
    begin bit seen; wait_done(seen); end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    run_cal(4'b0001, 0, 0);
    run_cal(4'b0100, 1, 2);
    run_cal(4'b1000, 0, 1);
    run_cal(4'b0011, 0, 0);
    run_cal(4'b0110, 1, 4);
    run_cal(4'b1100, 0, 2);
    run_cal(4'b0111, 1, 0);
    run_cal(4'b1110, 0, 3);
    run_cal(4'b1111, 1, 1);
    run_cal(4'b0000, 0, 0);
    run_cal(4'b0101, 1, 1);
    run_cal(4'b1101, 0, 2);
    test_restart();
    test_err_clear();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule